// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the serial test port of a device: a sixteen-state controller, advanced on each rising edge of the test clock and steered by the mode-select input, picks which internal register sits between the serial data input and the serial data output. A three-bit instruction, loaded through the instruction path, decides whether the data path is a single pass-through bit, a fixed 32-bit identification word, or a long boundary register. The boundary register takes a snapshot of the device pins from a parallel input vector and drives a parallel update vector back toward the pin cells.

One cell of the boundary register is special. Under the external-test instruction its latched value gates the device output drivers. A separate instruction releases every output to high impedance until another instruction is loaded. Serial data is shifted in at the most significant end of the selected register and leaves from its least significant end. The serial output is retimed to the falling test-clock edge and is enabled only while a register is being shifted.

Top module: `scan_tap_top`

## Requirements
- R1: The controller follows the sixteen-state test-port graph: mode-select is sampled on each rising test-clock edge, and a scan can pause (Exit1, Pause, Exit2) and resume shifting without losing bits.
- R2: The controller is in Test-Logic-Reset after the asynchronous reset, and five consecutive rising edges with mode-select high bring it to Test-Logic-Reset from any state.
- R3: In Capture-IR the instruction shift stage loads 3'b001 (the two low bits are 01); in Shift-IR serial input enters bit 2 and bit 0 is shifted out first.
- R4: The active instruction becomes IDCODE (3'b001) at reset and when Test-Logic-Reset is entered; otherwise it changes only in Update-IR, never while instruction bits are shifting.
- R5: Opcodes are EXTEST 3'b000, IDCODE 3'b001, SAMPLE-Z 3'b010, SAMPLE/PRELOAD 3'b100 and BYPASS 3'b111; the reserved codes 3'b011, 3'b101 and 3'b110 select the bypass bit.
- R6: The bypass register is one bit and captures 0 in Capture-DR.
- R7: Under IDCODE, Capture-DR loads the 32-bit word {revision[31:29], part code[28:12], manufacturer code[11:1], 1'b1}, shifted out bit 0 first.
- R8: Under EXTEST, SAMPLE-Z and SAMPLE/PRELOAD, Capture-DR loads the parallel capture vector into the boundary shift stage and Update-DR copies the shift stage to the parallel update vector; bit 0 is shifted out first.
- R9: While EXTEST is active, `ext_test_o` is 1 and `out_en_o` equals update-vector bit OE_CELL (1 drives, 0 high impedance); while SAMPLE-Z is active `out_en_o` is 0; under any other instruction `out_en_o` is 1 and `ext_test_o` is 0.
- R10: At reset and on entering Test-Logic-Reset the update vector is preset to all zeros except bit OE_CELL, which is 1.
- R11: The serial output and its enable change only on the falling test-clock edge; the enable is 1 only while the controller is in Shift-IR or Shift-DR, and the output is 0 whenever the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| test_mode_sel | input | 1 | Mode select, sampled on rising test-clock edges |
| test_din | input | 1 | Serial data input |
| test_dout | output | 1 | Serial data output, changes on falling edges |
| test_dout_en | output | 1 | Output enable for the serial data pin |
| bsr_capture_i | input | BSR_LEN | Pin snapshot loaded in Capture-DR |
| bsr_update_o | output | BSR_LEN | Latched boundary values toward the pin cells |
| ext_test_o | output | 1 | Boundary values own the pins (EXTEST active) |
| out_en_o | output | 1 | Device output drivers allowed to drive |

## Verification
The assertions take for granted that mode-select and serial input are settled around every rising test-clock edge, that the capture vector holds still across the Capture-DR edge, and that the reset input is asserted once before any clock activity. The stimulus applies every input change just after a falling edge, keeps the capture vector constant for a whole scan, and holds reset low over several clocks at the start. Outputs are read one nanosecond after each falling edge, so the retimed serial output is seen in the cycle it belongs to.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    localparam int unsigned IR_W = 3;

    localparam logic [IR_W-1:0] OPC_EXTEST   = 3'b000;
    localparam logic [IR_W-1:0] OPC_IDCODE   = 3'b001;
    localparam logic [IR_W-1:0] OPC_SAMPLE_Z = 3'b010;
    localparam logic [IR_W-1:0] OPC_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] OPC_BYPASS   = 3'b111;

    // value parked in the instruction shift stage on Capture-IR
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_IDENT,
        SEL_BOUND
    } dr_sel_e;

    function automatic dr_sel_e decode_sel(input logic [IR_W-1:0] opc);
        dr_sel_e s;
        case (opc)
            OPC_EXTEST, OPC_SAMPLE_Z, OPC_SAMPLE: s = SEL_BOUND;
            OPC_IDCODE:                           s = SEL_IDENT;
            default:                              s = SEL_BYPASS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tap_state_ctrl.sv
module tap_state_ctrl
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    output tap_state_e state_o,
    output logic       reset_next_o
);

    typedef struct packed {
        tap_state_e state;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_RESET:  d.state = mode_sel ? ST_RESET  : ST_IDLE;
            ST_IDLE:   d.state = mode_sel ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: d.state = mode_sel ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: d.state = mode_sel ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  d.state = mode_sel ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: d.state = mode_sel ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: d.state = mode_sel ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: d.state = mode_sel ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: d.state = mode_sel ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: d.state = mode_sel ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: d.state = mode_sel ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  d.state = mode_sel ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: d.state = mode_sel ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: d.state = mode_sel ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: d.state = mode_sel ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: d.state = mode_sel ? ST_SEL_DR : ST_IDLE;
            default:   d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_RESET};
        else        q <= d;
    end

    assign state_o      = q.state;
    assign reset_next_o = (d.state == ST_RESET);

    // run length of consecutive high mode-select samples, saturating at 5
    logic [2:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hi_run_q <= 3'd0;
        else if (!mode_sel)          hi_run_q <= 3'd0;
        else if (hi_run_q != 3'd5)   hi_run_q <= hi_run_q + 3'd1;
    end

    assert_five_high_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run_q == 3'd5) |-> (q.state == ST_RESET));

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
    import scan_tap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_in,
    input  tap_state_e      state_i,
    input  logic            reset_next_i,
    output logic [IR_W-1:0] instr_o,
    output logic            ser_out_o
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] cur;
    } ir_t;

    ir_t d, q;

    always_comb begin
        d = q;
        if (reset_next_i) begin
            d.sh  = OPC_IDCODE;
            d.cur = OPC_IDCODE;
        end else begin
            case (state_i)
                ST_CAP_IR: d.sh  = IR_CAPTURE;
                ST_SH_IR:  d.sh  = {ser_in, q.sh[IR_W-1:1]};
                ST_UPD_IR: d.cur = q.sh;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: OPC_IDCODE, cur: OPC_IDCODE};
        else        q <= d;
    end

    assign instr_o   = q.cur;
    assign ser_out_o = q.sh[0];

    assert_capture_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_CAP_IR && !reset_next_i) |=> (q.sh[1:0] == 2'b01));

    assert_instr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_UPD_IR && !reset_next_i) |=> $stable(q.cur));

endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 107,
    parameter int unsigned OE_CELL = 47,
    parameter int unsigned REV_W   = 3,
    parameter int unsigned PART_W  = 17,
    parameter int unsigned MFR_W   = 11,
    parameter logic [REV_W-1:0]  ID_REV  = 3'b101,
    parameter logic [PART_W-1:0] ID_PART = 17'h0A5C3,
    parameter logic [MFR_W-1:0]  ID_MFR  = 11'h034
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_in,
    input  tap_state_e         state_i,
    input  logic               reset_next_i,
    input  dr_sel_e            sel_i,
    input  logic [BSR_LEN-1:0] cap_vec_i,
    output logic [BSR_LEN-1:0] upd_vec_o,
    output logic               ser_out_o
);

    localparam int unsigned ID_W = REV_W + PART_W + MFR_W + 1;
    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_MFR, 1'b1};

    // preset pattern of the update stage: only the enable cell is set
    logic [BSR_LEN-1:0] preset_vec;
    for (genvar gi = 0; gi < BSR_LEN; gi++) begin : g_preset
        if (gi == OE_CELL) begin : g_oe
            assign preset_vec[gi] = 1'b1;
        end else begin : g_plain
            assign preset_vec[gi] = 1'b0;
        end
    end

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] sh;
        logic [BSR_LEN-1:0] upd;
    } dr_t;

    dr_t d, q;

    always_comb begin
        d = q;
        case (state_i)
            ST_CAP_DR: begin
                case (sel_i)
                    SEL_BOUND: d.sh  = cap_vec_i;
                    SEL_IDENT: d.id  = ID_WORD;
                    default:   d.byp = 1'b0;
                endcase
            end
            ST_SH_DR: begin
                case (sel_i)
                    SEL_BOUND: d.sh  = {ser_in, q.sh[BSR_LEN-1:1]};
                    SEL_IDENT: d.id  = {ser_in, q.id[ID_W-1:1]};
                    default:   d.byp = ser_in;
                endcase
            end
            ST_UPD_DR: begin
                if (sel_i == SEL_BOUND) d.upd = q.sh;
            end
            default: ;
        endcase
        if (reset_next_i) d.upd = preset_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.byp <= 1'b0;
            q.id  <= '0;
            q.sh  <= '0;
            q.upd <= preset_vec;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (sel_i)
            SEL_BOUND: ser_out_o = q.sh[0];
            SEL_IDENT: ser_out_o = q.id[0];
            default:   ser_out_o = q.byp;
        endcase
    end

    assign upd_vec_o = q.upd;

    assert_bypass_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_CAP_DR && sel_i == SEL_BYPASS) |=> (q.byp == 1'b0));

    assert_oe_preset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_RESET) |=> (q.upd[OE_CELL] == 1'b1));

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 107,
    parameter int unsigned OE_CELL = 47,
    parameter int unsigned REV_W   = 3,
    parameter int unsigned PART_W  = 17,
    parameter int unsigned MFR_W   = 11,
    parameter logic [REV_W-1:0]  ID_REV  = 3'b101,
    parameter logic [PART_W-1:0] ID_PART = 17'h0A5C3,
    parameter logic [MFR_W-1:0]  ID_MFR  = 11'h034
) (
    input  logic               test_clk,
    input  logic               rst_n,
    input  logic               test_mode_sel,
    input  logic               test_din,
    output logic               test_dout,
    output logic               test_dout_en,
    input  logic [BSR_LEN-1:0] bsr_capture_i,
    output logic [BSR_LEN-1:0] bsr_update_o,
    output logic               ext_test_o,
    output logic               out_en_o
);

    tap_state_e      state;
    logic            reset_next;
    logic [IR_W-1:0] instr;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_e         sel;

    tap_state_ctrl u_fsm (
        .clk          (test_clk),
        .rst_n        (rst_n),
        .mode_sel     (test_mode_sel),
        .state_o      (state),
        .reset_next_o (reset_next)
    );

    tap_instr_reg u_ir (
        .clk          (test_clk),
        .rst_n        (rst_n),
        .ser_in       (test_din),
        .state_i      (state),
        .reset_next_i (reset_next),
        .instr_o      (instr),
        .ser_out_o    (ir_lsb)
    );

    assign sel = decode_sel(instr);

    tap_data_regs #(
        .BSR_LEN (BSR_LEN),
        .OE_CELL (OE_CELL),
        .REV_W   (REV_W),
        .PART_W  (PART_W),
        .MFR_W   (MFR_W),
        .ID_REV  (ID_REV),
        .ID_PART (ID_PART),
        .ID_MFR  (ID_MFR)
    ) u_dr (
        .clk          (test_clk),
        .rst_n        (rst_n),
        .ser_in       (test_din),
        .state_i      (state),
        .reset_next_i (reset_next),
        .sel_i        (sel),
        .cap_vec_i    (bsr_capture_i),
        .upd_vec_o    (bsr_update_o),
        .ser_out_o    (dr_lsb)
    );

    // pin gating from the active instruction
    always_comb begin
        ext_test_o = (instr == OPC_EXTEST);
        if (ext_test_o)                  out_en_o = bsr_update_o[OE_CELL];
        else if (instr == OPC_SAMPLE_Z)  out_en_o = 1'b0;
        else                             out_en_o = 1'b1;
    end

    // serial output stage, retimed on the falling edge
    typedef struct packed {
        logic dout;
        logic en;
    } so_t;

    so_t so_d, so_q;

    always_comb begin
        so_d = '0;
        if (state == ST_SH_IR) begin
            so_d.en   = 1'b1;
            so_d.dout = ir_lsb;
        end else if (state == ST_SH_DR) begin
            so_d.en   = 1'b1;
            so_d.dout = dr_lsb;
        end
    end

    always_ff @(negedge test_clk or negedge rst_n) begin
        if (!rst_n) so_q <= '0;
        else        so_q <= so_d;
    end

    assign test_dout    = so_q.dout;
    assign test_dout_en = so_q.en;

    assert_dout_only_shift_R11: assert property (@(posedge test_clk) disable iff (!rst_n)
        test_dout_en |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

// File: tb/sim_scan_tap_top.sv
`timescale 1ns/1ps
module sim_scan_tap_top;

    localparam int BSR_LEN = 107;
    localparam int OE_CELL = 47;
    localparam logic [2:0]  T_REV  = 3'b101;
    localparam logic [16:0] T_PART = 17'h0A5C3;
    localparam logic [10:0] T_MFR  = 11'h034;
    localparam logic [31:0] T_ID   = {T_REV, T_PART, T_MFR, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en, ext, oe;
    logic [BSR_LEN-1:0] cap, upd;

    always #10 clk = ~clk;

    scan_tap_top #(
        .BSR_LEN (BSR_LEN),
        .OE_CELL (OE_CELL),
        .ID_REV  (T_REV),
        .ID_PART (T_PART),
        .ID_MFR  (T_MFR)
    ) u0 (
        .test_clk      (clk),
        .rst_n         (rst_n),
        .test_mode_sel (tms),
        .test_din      (tdi),
        .test_dout     (tdo),
        .test_dout_en  (tdo_en),
        .bsr_capture_i (cap),
        .bsr_update_o  (upd),
        .ext_test_o    (ext),
        .out_en_o      (oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] got);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            got[i] = tdo;
            step(i == 2, code[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] got);
        got = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            got[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    // rows: {opcode[2:0], register kind[1:0] (0 bypass,1 id,2 boundary), out_en, ext}
    localparam logic [6:0] ROWS [8] = '{
        {3'b000, 2'd2, 1'b1, 1'b1},
        {3'b001, 2'd1, 1'b1, 1'b0},
        {3'b010, 2'd2, 1'b0, 1'b0},
        {3'b011, 2'd0, 1'b1, 1'b0},
        {3'b100, 2'd2, 1'b1, 1'b0},
        {3'b101, 2'd0, 1'b1, 1'b0},
        {3'b110, 2'd0, 1'b1, 1'b0},
        {3'b111, 2'd0, 1'b1, 1'b0}
    };

    logic [BSR_LEN-1:0] preset_exp;

    initial begin
        logic [2:0]   irv;
        logic [127:0] got;
        logic [127:0] exp4;
        logic [BSR_LEN-1:0] pat;

        for (int i = 0; i < BSR_LEN; i++) cap[i] = ((i * 5 + 3) % 7) < 3;
        cap[51] = 1'b1;
        cap[47] = 1'b0;
        preset_exp = '0;
        preset_exp[OE_CELL] = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // reset state
        chk("R11 reset dout_en", tdo_en, 0);
        chk("R10 reset update preset", upd, preset_exp);
        chk("R9 reset out_en", oe, 1);
        chk("R9 reset ext", ext, 0);

        step(0, 0);
        chk("R11 idle dout_en", tdo_en, 0);
        scan_dr(32, 0, got);
        chk("R7 R4 idcode after reset", got, T_ID);

        // table walk across all opcodes
        for (int r = 0; r < 8; r++) begin
            scan_ir(ROWS[r][6:4], irv);
            chk("R3 capture-ir pattern", irv, 3'b001);
            scan_dr(4, 128'hB, got);
            case (ROWS[r][3:2])
                2'd0:    exp4 = 128'h6;           // R6 captured 0 then input bits
                2'd1:    exp4 = T_ID[3:0];
                default: exp4 = cap[3:0];
            endcase
            chk("R5 R6 R8 selected register", got, exp4);
            chk("R9 out_en per opcode", oe, ROWS[r][1]);
            chk("R9 ext per opcode", ext, ROWS[r][0]);
        end

        // full boundary scan under EXTEST
        scan_ir(3'b000, irv);
        for (int i = 0; i < BSR_LEN; i++) pat[i] = ((i * 3 + 1) % 5) < 2;
        pat[OE_CELL] = 1'b0;
        scan_dr(BSR_LEN, 128'(pat), got);
        chk("R8 boundary capture", got, 128'(cap));
        chk("R8 boundary update", upd, pat);
        chk("R9 extest enable cell 0", oe, 0);

        // instruction holds while shifting
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        chk("R11 dout_en in shift-ir", tdo_en, 1);
        step(0, 0); step(0, 1);
        chk("R4 out_en held during ir shift", oe, 0);
        chk("R4 ext held during ir shift", ext, 1);
        step(1, 0);
        chk("R4 ext held in exit1-ir", ext, 1);
        step(1, 0); step(0, 0);
        chk("R9 sample-z out_en", oe, 0);
        chk("R9 sample-z ext", ext, 0);
        chk("R11 idle dout", {tdo_en, tdo}, 2'b00);

        // pause and resume in a data scan, under bypass
        scan_ir(3'b111, irv);
        step(1, 0); step(0, 0); step(0, 0);
        chk("R6 bypass capture", tdo, 0);
        step(1, 1);
        step(0, 0);
        chk("R1 pause dout_en", tdo_en, 0);
        step(1, 0);
        step(0, 0);
        chk("R1 resume shift keeps bit", {tdo_en, tdo}, 2'b11);
        step(1, 0); step(1, 0); step(0, 0);

        // set enable cell to 0 under EXTEST, then force reset with five highs
        scan_ir(3'b000, irv);
        chk("R9 extest cell from last update", oe, 0);
        step(1, 0); step(0, 0); step(0, 0);
        repeat (5) step(1, 0);
        chk("R2 R11 reset reached dout_en", tdo_en, 0);
        chk("R10 update preset on reset", upd, preset_exp);
        chk("R4 idcode on reset ext", ext, 0);
        step(0, 0);
        scan_dr(32, 0, got);
        chk("R2 R4 idcode after five highs", got, T_ID);
        scan_ir(3'b000, irv);
        chk("R10 preset cell enables", oe, 1);
        chk("R9 extest ext", ext, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule